// File: doc/BRIEF.md
# Dual-Mode AES Column Mixer

This block applies either the forward column mixing transform or its inverse to a full 128-bit AES State in a single registered step. The State is split into four 32-bit columns, and each column is treated as a four-term polynomial over GF(2^8). All four columns are processed at the same time and independently. A mode input selects which matrix applies.

In forward mode the block serves encryption rounds. In inverse mode it serves decryption rounds. The inverse mode also turns encryption round keys into the modified keys that the equivalent inverse cipher needs, so that decryption can use the same order of round steps as encryption. The result appears one clock after the input, and the valid flag travels with it.

Byte layout: bits [127:120] hold column 0 row 0, [119:112] hold column 0 row 1, and so on, so column c occupies bits [127-32c -: 32] with row 0 in its top byte.

Top module: `aesColMixer`

## Requirements
- R1: During reset, and in the first cycle after it, outValid is 0 and outWord is all zeros.
- R2: GF(2^8) products use reduction by x^8+x^4+x^3+x+1. Doubling shifts left and XORs 0x1B when bit 7 was set.
- R3: With mode=0 (forward), output row r of each column is the dot product of that column with the row 02 03 01 01 rotated right by r positions.
- R4: With mode=1 (inverse), output row r of each column is the dot product of that column with the row 0e 0b 0d 09 rotated right by r positions.
- R5: The four columns are transformed independently. Changing one column changes only that column of the output.
- R6: The output for an input sampled at clock edge k appears after edge k. outValid at that point equals inValid at edge k, so latency is one cycle.
- R7: When inValid is 0, outWord holds its previous value and outValid goes to 0.
- R8: The inverse mode applied to the forward mode's output returns the original word. The column db 13 53 45 maps forward to 8e 4d a1 bc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word is valid |
| mode | input | 1 | 0 = forward mix, 1 = inverse mix |
| inWord | input | 128 | State or round key to transform |
| outWord | output | 128 | Transformed word, registered |
| outValid | output | 1 | outWord was updated this cycle |

## Verification
The bench feeds the bytes db 13 53 45 and random words in both modes. It compares each output, one cycle later, with a behavioural GF model. A wrong reduction constant or a wrong xtime condition would corrupt any byte that has its top bit set. A wrong rotation direction in either matrix would show up in the known vector and in the inverse round-trip. Single-column stimulus catches bytes leaking between columns. Idle cycles with changing inputs catch a register that loads while inValid is low.

// File: rtl/aesColMixPkg.sv
package aesColMixPkg;
  localparam int BYTE_W  = 8;
  localparam int ROWS    = 4;
  localparam int COLS    = 4;
  localparam int COL_W   = BYTE_W * ROWS;
  localparam int STATE_W = COL_W * COLS;
  localparam logic [BYTE_W-1:0] REDUCE = 8'h1B;

  typedef struct packed {
    logic load;
    logic validNext;
  } mixCtrl_t;

  function automatic logic [BYTE_W-1:0] xtime(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? REDUCE : '0);
  endfunction
endpackage

// File: rtl/aesGfMul.sv
module aesGfMul
  import aesColMixPkg::*;
(
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] m2,
  output logic [BYTE_W-1:0] m3,
  output logic [BYTE_W-1:0] m9,
  output logic [BYTE_W-1:0] mB,
  output logic [BYTE_W-1:0] mD,
  output logic [BYTE_W-1:0] mE
);
  logic [BYTE_W-1:0] x2, x4, x8;
  always_comb begin
    x2 = xtime(a);
    x4 = xtime(x2);
    x8 = xtime(x4);
    m2 = x2;
    m3 = x2 ^ a;
    m9 = x8 ^ a;
    mB = x8 ^ x2 ^ a;
    mD = x8 ^ x4 ^ a;
    mE = x8 ^ x4 ^ x2;
  end
endmodule

// File: rtl/aesMixColumn.sv
module aesMixColumn
  import aesColMixPkg::*;
(
  input  logic             inverse,
  input  logic [COL_W-1:0] colIn,
  output logic [COL_W-1:0] colOut
);
  logic [BYTE_W-1:0] b  [ROWS];
  logic [BYTE_W-1:0] p2 [ROWS];
  logic [BYTE_W-1:0] p3 [ROWS];
  logic [BYTE_W-1:0] p9 [ROWS];
  logic [BYTE_W-1:0] pB [ROWS];
  logic [BYTE_W-1:0] pD [ROWS];
  logic [BYTE_W-1:0] pE [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign b[r] = colIn[COL_W-1-BYTE_W*r -: BYTE_W];
    aesGfMul i_mul (
      .a(b[r]), .m2(p2[r]), .m3(p3[r]), .m9(p9[r]),
      .mB(pB[r]), .mD(pD[r]), .mE(pE[r])
    );
    localparam int R1I = (r + 1) % ROWS;
    localparam int R2I = (r + 2) % ROWS;
    localparam int R3I = (r + 3) % ROWS;
    logic [BYTE_W-1:0] fwd, inv;
    assign fwd = p2[r] ^ p3[R1I] ^ b[R2I] ^ b[R3I];
    assign inv = pE[r] ^ pB[R1I] ^ pD[R2I] ^ p9[R3I];
    assign colOut[COL_W-1-BYTE_W*r -: BYTE_W] = inverse ? inv : fwd;
  end
endmodule

// File: rtl/aesMixDatapath.sv
module aesMixDatapath
  import aesColMixPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  mixCtrl_t           ctrl,
  input  logic               inverse,
  input  logic [STATE_W-1:0] dataIn,
  output logic [STATE_W-1:0] dataOut,
  output logic               validOut
);
  logic [STATE_W-1:0] mixed;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    aesMixColumn i_col (
      .inverse(inverse),
      .colIn (dataIn[STATE_W-1-COL_W*c -: COL_W]),
      .colOut(mixed [STATE_W-1-COL_W*c -: COL_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut  <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= ctrl.validNext;
      if (ctrl.load) dataOut <= mixed;
    end
  end
endmodule

// File: rtl/aesMixCtrl.sv
module aesMixCtrl
  import aesColMixPkg::*;
(
  input  logic     inValid,
  output mixCtrl_t ctrl
);
  always_comb begin
    ctrl.load      = inValid;
    ctrl.validNext = inValid;
  end
endmodule

// File: rtl/aesColMixer.sv
module aesColMixer
  import aesColMixPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         mode,
  input  logic [127:0] inWord,
  output logic [127:0] outWord,
  output logic         outValid
);
  mixCtrl_t ctrl;

  aesMixCtrl i_ctrl (.inValid(inValid), .ctrl(ctrl));

  aesMixDatapath i_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .inverse(mode),
    .dataIn(inWord), .dataOut(outWord), .validOut(outValid)
  );
endmodule

// File: rtl/aesColMixerChk.sv
module aesColMixerChk (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         mode,
  input logic [127:0] inWord,
  input logic [127:0] outWord,
  input logic         outValid
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!outValid && outWord == '0));
  p_valid_lat_r6: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst) !inValid |=> $stable(outWord));
  p_idle_novalid_r7: assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid);
  p_zero_map_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inWord == '0) |=> outWord == '0);
endmodule

bind aesColMixer aesColMixerChk i_chk (.*);

// File: tb/test_aesColMixer.sv
module test_aesColMixer;
  logic clk = 0, rst = 1, inValid = 0, mode = 0;
  logic [127:0] inWord = '0;
  logic [127:0] outWord;
  logic outValid;
  int checks = 0, errors = 0;
  logic [127:0] expWord = '0;
  logic expValid = 0;
  logic [127:0] fwdStore [8];

  always #5 clk = ~clk;

  aesColMixer i_aesColMixer (.*);

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    end
    return p;
  endfunction

  function automatic logic [127:0] refMix(input logic [127:0] w, input logic inv);
    logic [7:0] k [4];
    logic [127:0] o;
    logic [7:0] s;
    if (inv) k = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else k = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        s = 0;
        for (int j = 0; j < 4; j++)
          s ^= gmul(w[127 - 32*c - 8*j -: 8], k[(j - r + 4) % 4]);
        o[127 - 32*c - 8*r -: 8] = s;
      end
    return o;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model compared every clock (R6, R7)
  always @(negedge clk) begin
    if (!rst) begin
      check("R6 valid", {127'b0, outValid}, {127'b0, expValid});
      check("R3/R4 word", outWord, expWord);
    end
  end
  always @(posedge clk) begin
    if (rst) begin expWord <= '0; expValid <= 0; end
    else begin
      expValid <= inValid;
      if (inValid) expWord <= refMix(inWord, mode);
    end
  end

  task automatic drive(input logic v, input logic m, input logic [127:0] w);
    @(negedge clk); inValid = v; mode = m; inWord = w;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] w;
    repeat (3) @(negedge clk);
    check("R1 reset word", outWord, '0);
    check("R1 reset valid", {127'b0, outValid}, 128'b0);
    rst = 0;
    @(negedge clk);
    check("R1 post-reset", {outWord[126:0], outValid}, '0);

    // R8/R2 known vector in column 0
    drive(1, 0, {32'hdb135345, 96'h0});
    drive(0, 0, '0);
    check("R8 known fwd", outWord, {32'h8e4da1bc, 96'h0});
    // R4 known inverse
    drive(1, 1, {32'h8e4da1bc, 96'h0});
    drive(0, 1, '0);
    check("R4 known inv", outWord, {32'hdb135345, 96'h0});
    // R5 single column 2, others zero
    drive(1, 0, {64'h0, 32'hdb135345, 32'h0});
    drive(0, 0, '0);
    check("R5 column isolation", outWord, {64'h0, 32'h8e4da1bc, 32'h0});
    // R7 idle with changing inputs holds output
    w = outWord;
    drive(0, 1, {4{32'hffffffff}});
    drive(0, 0, {4{32'h12345678}});
    check("R7 idle hold", outWord, w);
    // R2 high-bit bytes: 80 column forward -> 1b 80 80 9b
    drive(1, 0, {32'h80000000, 96'h0});
    drive(0, 0, '0);
    check("R2 reduction", outWord, {32'h1b80809b, 96'h0});
    // R8 round trip on random words, back-to-back
    for (int i = 0; i < 8; i++) begin
      w = {$urandom, $urandom, $urandom, $urandom};
      drive(1, 0, w);
      @(negedge clk);
      check("R3 random fwd", outWord, refMix(w, 0));
      fwdStore[i] = outWord;
      inValid = 1; mode = 1; inWord = fwdStore[i];
      @(negedge clk);
      check("R8 round trip", outWord, w);
      inValid = 0;
    end
    drive(0, 0, '0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule